// File: doc/BRIEF.md
# Interrupt Aggregator and Output Port Register

This block gathers the interrupt sources of a two-channel serial controller and its timer into one eight-bit status register. It masks that register with a mask written by the host and raises a single interrupt request. A host-programmed vector byte is presented beside the request. Set events come in as single-cycle pulses from the channels and the timer. Clear events come from host accesses that the block decodes on its own register bus: a read of a channel's data address, a write of a channel's data address, or a transmitter command.

The same bus also reaches an eight-bit general output register and an eight-bit output configuration register. The output register has no plain write. Bits are raised through a write-one-to-set address and dropped through a write-one-to-clear address. Read data is combinational from the current register state. Side effects of an access take effect at the clock edge that ends the access cycle.

Register map (bus_addr): 0 status read / mask write, 1 vector, 2 output set (reads output), 3 output clear (reads output), 4 output configuration, 5 channel A command, 6 channel A data, 7 channel B command, 8 channel B data. Every other address reads zero and has no effect.

Top module: `irq_outport`

## Requirements
- R1: After reset the status, mask, vector, output and configuration registers are zero and irq_req is low.
- R2: irq_req is high exactly when the status register ANDed with the mask register is nonzero. It follows the registers in the same cycle.
- R3: With bus_sel high, address 0 reads the status register. A write to address 0 loads the mask and leaves the status unchanged. With bus_sel low, bus_rdata is zero.
- R4: A write to address 1 loads the vector. irq_vec always shows the vector and changes only on such a write. Address 1 reads the vector back.
- R5: A write to address 2 ORs bus_wdata into the output register. Addresses 2 and 3 read the output register.
- R6: A write to address 3 clears every output bit whose bus_wdata bit is 1 and leaves the other bits as they were.
- R7: A write to address 4 loads the configuration register. Address 4 reads it back, and out_cfg shows it.
- R8: Status bit 1 (channel A) and bit 5 (channel B) receiver-ready are set by rx_rdy_set[0] and rx_rdy_set[1]. They are cleared by a read of address 6 and of address 8 respectively.
- R9: Status bit 0 (channel A) and bit 4 (channel B) transmitter-ready are set by tx_rdy_set[0] and tx_rdy_set[1]. They are cleared by a write of address 6 and of address 8 respectively.
- R10: In a write to a command address (5 for A, 7 for B), bus_wdata[3:2]=01 sets that channel's transmitter-ready bit and 10 clears it. The codes 00 and 11 leave it unchanged.
- R11: Status bit 3 is set by tmr_set and cleared by tmr_clr.
- R12: When a set event and a clear event reach the same status bit in one cycle, the bit ends up set.
- R13: Status bits 7, 6 and 2 (input change, channel B and channel A break change) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe for the access |
| bus_rd | input | 1 | Read strobe for the access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_rdy_set | input | 2 | Receiver-ready set pulses, one per channel |
| tx_rdy_set | input | 2 | Transmitter-ready set pulses, one per channel |
| tmr_set | input | 1 | Timer event set pulse |
| tmr_clr | input | 1 | Timer event clear pulse |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Interrupt vector byte |
| out_port | output | 8 | General output register |
| out_cfg | output | 8 | Output configuration register |

## Verification
The assertions check these rules on every cycle:
- a receiver or timer set pulse always leaves its bit set, even when a clear arrives with it;
- the output register obeys the set and clear writes;
- the vector holds between its writes;
- no request rises while the mask is empty;
- a channel A data write clears its transmitter bit.

The bench scenarios are what show the full register map, the command codes 00 and 11, and the reserved status bits. They compare every output against a bench model under directed collisions and a long random mix of accesses and events.

// File: rtl/irqo_pkg.sv
package irqo_pkg;
    localparam int DW     = 8;
    localparam int AW     = 4;
    localparam int NUM_CH = 2;

    // status bit positions
    localparam int B_TXA   = 0;
    localparam int B_RXA   = 1;
    localparam int B_BRKA  = 2;
    localparam int B_TMR   = 3;
    localparam int B_TXB   = 4;
    localparam int B_RXB   = 5;
    localparam int B_BRKB  = 6;
    localparam int B_INCHG = 7;

    // bits that carry a live source; the others are tied inactive
    localparam logic [DW-1:0] LIVE_MASK = (DW'(1) << B_TXA) | (DW'(1) << B_RXA) |
                                          (DW'(1) << B_TMR) | (DW'(1) << B_TXB) |
                                          (DW'(1) << B_RXB);

    typedef enum logic [AW-1:0] {
        A_STAT_MASK = 4'd0,
        A_VEC       = 4'd1,
        A_OSET      = 4'd2,
        A_OCLR      = 4'd3,
        A_OCFG      = 4'd4,
        A_CMD_A     = 4'd5,
        A_DAT_A     = 4'd6,
        A_CMD_B     = 4'd7,
        A_DAT_B     = 4'd8
    } reg_sel_e;

    typedef enum logic [1:0] {
        TXC_NONE = 2'b00,
        TXC_ON   = 2'b01,
        TXC_OFF  = 2'b10,
        TXC_RSVD = 2'b11
    } tx_cmd_e;

    typedef struct packed {
        logic              wr_mask;
        logic              wr_vec;
        logic              wr_oset;
        logic              wr_oclr;
        logic              wr_ocfg;
        logic [NUM_CH-1:0] wr_cmd;
        logic [NUM_CH-1:0] wr_dat;
        logic [NUM_CH-1:0] rd_dat;
    } strobe_t;

    function automatic int tx_bit(input int ch);
        return 4 * ch;
    endfunction

    function automatic int rx_bit(input int ch);
        return 4 * ch + 1;
    endfunction
endpackage

// File: rtl/irqo_decode.sv
module irqo_decode
    import irqo_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [1:0]        cmd_code,
    output strobe_t           strb,
    output logic [NUM_CH-1:0] tx_on,
    output logic [NUM_CH-1:0] tx_off
);
    logic wr_go;
    logic rd_go;

    assign wr_go = bus_sel & bus_wr;
    assign rd_go = bus_sel & bus_rd;

    always_comb begin
        strb = '0;
        unique case (reg_sel_e'(bus_addr))
            A_STAT_MASK: strb.wr_mask   = wr_go;
            A_VEC:       strb.wr_vec    = wr_go;
            A_OSET:      strb.wr_oset   = wr_go;
            A_OCLR:      strb.wr_oclr   = wr_go;
            A_OCFG:      strb.wr_ocfg   = wr_go;
            A_CMD_A:     strb.wr_cmd[0] = wr_go;
            A_DAT_A: begin
                strb.wr_dat[0] = wr_go;
                strb.rd_dat[0] = rd_go;
            end
            A_CMD_B:     strb.wr_cmd[1] = wr_go;
            A_DAT_B: begin
                strb.wr_dat[1] = wr_go;
                strb.rd_dat[1] = rd_go;
            end
            default: ;
        endcase
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmd
        assign tx_on[c]  = strb.wr_cmd[c] & (tx_cmd_e'(cmd_code) == TXC_ON);
        assign tx_off[c] = strb.wr_cmd[c] & (tx_cmd_e'(cmd_code) == TXC_OFF);
    end
endmodule

// File: rtl/irqo_status.sv
module irqo_status
    import irqo_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_vec,
    input  logic [DW-1:0] clr_vec,
    output logic [DW-1:0] stat_q
);
    logic [DW-1:0] stat_d;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        // a set in the same cycle as a clear wins
        assign stat_d[i] = LIVE_MASK[i] & (set_vec[i] | (stat_q[i] & ~clr_vec[i]));

        always_ff @(posedge clk) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= stat_d[i];
        end
    end
endmodule

// File: rtl/irqo_outreg.sv
module irqo_outreg
    import irqo_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_set,
    input  logic          wr_clr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] out_q
);
    logic [DW-1:0] set_m;
    logic [DW-1:0] clr_m;

    assign set_m = wr_set ? wdata : '0;
    assign clr_m = wr_clr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= (out_q | set_m) & ~clr_m;
    end
endmodule

// File: rtl/irq_outport.sv
module irq_outport
    import irqo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0] rx_rdy_set,
    input  logic [NUM_CH-1:0] tx_rdy_set,
    input  logic              tmr_set,
    input  logic              tmr_clr,
    output logic              irq_req,
    output logic [DW-1:0]     irq_vec,
    output logic [DW-1:0]     out_port,
    output logic [DW-1:0]     out_cfg
);
    strobe_t           strb;
    logic [NUM_CH-1:0] tx_on;
    logic [NUM_CH-1:0] tx_off;
    logic [DW-1:0]     set_v;
    logic [DW-1:0]     clr_v;
    logic [DW-1:0]     stat_q;
    logic [DW-1:0]     mask_q;
    logic [DW-1:0]     vec_q;
    logic [DW-1:0]     cfg_q;

    irqo_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .cmd_code (bus_wdata[3:2]),
        .strb     (strb),
        .tx_on    (tx_on),
        .tx_off   (tx_off)
    );

    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            set_v[tx_bit(c)] = tx_rdy_set[c] | tx_on[c];
            clr_v[tx_bit(c)] = strb.wr_dat[c] | tx_off[c];
            set_v[rx_bit(c)] = rx_rdy_set[c];
            clr_v[rx_bit(c)] = strb.rd_dat[c];
        end
        set_v[B_TMR] = tmr_set;
        clr_v[B_TMR] = tmr_clr;
    end

    irqo_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_v),
        .clr_vec (clr_v),
        .stat_q  (stat_q)
    );

    irqo_outreg u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (strb.wr_oset),
        .wr_clr (strb.wr_oclr),
        .wdata  (bus_wdata),
        .out_q  (out_port)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            vec_q  <= '0;
            cfg_q  <= '0;
        end else begin
            if (strb.wr_mask) mask_q <= bus_wdata;
            if (strb.wr_vec)  vec_q  <= bus_wdata;
            if (strb.wr_ocfg) cfg_q  <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (reg_sel_e'(bus_addr))
                A_STAT_MASK:   bus_rdata = stat_q;
                A_VEC:         bus_rdata = vec_q;
                A_OSET, A_OCLR: bus_rdata = out_port;
                A_OCFG:        bus_rdata = cfg_q;
                default:       bus_rdata = '0;
            endcase
        end
    end

    assign irq_req = |(stat_q & mask_q);
    assign irq_vec = vec_q;
    assign out_cfg = cfg_q;
endmodule

// File: rtl/irqo_chk.sv
module irqo_chk
    import irqo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [NUM_CH-1:0] rx_rdy_set,
    input logic [NUM_CH-1:0] tx_rdy_set,
    input logic              tmr_set,
    input logic              irq_req,
    input logic [DW-1:0]     irq_vec,
    input logic [DW-1:0]     out_port,
    input logic [DW-1:0]     stat_q,
    input logic [DW-1:0]     mask_q
);
    logic wr_any;
    assign wr_any = bus_sel & bus_wr;

    // R12
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rdy_set[0] |=> stat_q[B_RXA]);

    // R11
    tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_set |=> stat_q[B_TMR]);

    // R5
    oset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_OSET) |=> ((out_port & $past(bus_wdata)) == $past(bus_wdata)));

    // R6
    oclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_OCLR) |=> ((out_port & $past(bus_wdata)) == '0));

    // R4
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && bus_addr == A_VEC) |=> $stable(irq_vec));

    // R2
    no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_req);

    // R9
    txa_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == A_DAT_A && !tx_rdy_set[0]) |=> !stat_q[B_TXA]);
endmodule

bind irq_outport irqo_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rx_rdy_set (rx_rdy_set),
    .tx_rdy_set (tx_rdy_set),
    .tmr_set    (tmr_set),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .out_port   (out_port),
    .stat_q     (stat_q),
    .mask_q     (mask_q)
);

// File: tb/test_irq_outport.sv
`timescale 1ns/1ps
module test_irq_outport;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel, bus_wr, bus_rd;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [1:0] rx_rdy_set, tx_rdy_set;
    logic       tmr_set, tmr_clr;
    logic       irq_req;
    logic [7:0] irq_vec, out_port, out_cfg;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // bench model of the visible state
    logic [7:0] m_stat, m_mask, m_vec, m_out, m_cfg;

    always #2.5 clk = ~clk;

    irq_outport i_irq_outport (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_rdy_set(rx_rdy_set), .tx_rdy_set(tx_rdy_set), .tmr_set(tmr_set), .tmr_clr(tmr_clr),
        .irq_req(irq_req), .irq_vec(irq_vec), .out_port(out_port), .out_cfg(out_cfg)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // R3 R4 R5 R6 R7: expected read data from the register map
    function automatic logic [7:0] f_rdata(input logic sel, input logic [3:0] a);
        if (!sel) return 8'h00;
        case (a)
            4'd0:       return m_stat;
            4'd1:       return m_vec;
            4'd2, 4'd3: return m_out;
            4'd4:       return m_cfg;
            default:    return 8'h00;
        endcase
    endfunction

    // R8 R9 R10 R11 R12 R13: next status from events; sets override clears
    function automatic logic [7:0] f_stat_next(input logic sel, input logic wr, input logic rd,
            input logic [3:0] a, input logic [7:0] wd, input logic [1:0] rx,
            input logic [1:0] tx, input logic ts, input logic tc);
        logic [7:0] s, c;
        s = '0; c = '0;
        s[1] = rx[0]; s[5] = rx[1];
        s[0] = tx[0]; s[4] = tx[1];
        s[3] = ts;    c[3] = tc;
        if (sel && rd && a == 4'd6) c[1] = 1'b1;
        if (sel && rd && a == 4'd8) c[5] = 1'b1;
        if (sel && wr && a == 4'd6) c[0] = 1'b1;
        if (sel && wr && a == 4'd8) c[4] = 1'b1;
        if (sel && wr && a == 4'd5 && wd[3:2] == 2'b01) s[0] = 1'b1;
        if (sel && wr && a == 4'd5 && wd[3:2] == 2'b10) c[0] = 1'b1;
        if (sel && wr && a == 4'd7 && wd[3:2] == 2'b01) s[4] = 1'b1;
        if (sel && wr && a == 4'd7 && wd[3:2] == 2'b10) c[4] = 1'b1;
        return (s | (m_stat & ~c)) & 8'b0011_1011;
    endfunction

    task automatic cyc(input string req, input logic sel, input logic wr, input logic rd,
            input logic [3:0] a, input logic [7:0] wd, input logic [1:0] rx,
            input logic [1:0] tx, input logic ts, input logic tc);
        logic [7:0] nstat;
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        rx_rdy_set = rx; tx_rdy_set = tx; tmr_set = ts; tmr_clr = tc;
        #1;
        chk(req, "rdata", bus_rdata, f_rdata(sel, a));
        chk("R2", "irq_req", {7'd0, irq_req}, {7'd0, |(m_stat & m_mask)});
        chk("R4", "irq_vec", irq_vec, m_vec);
        chk("R5 R6", "out_port", out_port, m_out);
        chk("R7", "out_cfg", out_cfg, m_cfg);
        nstat = f_stat_next(sel, wr, rd, a, wd, rx, tx, ts, tc);
        if (sel && wr) begin
            case (a)
                4'd0: m_mask = wd;
                4'd1: m_vec  = wd;
                4'd2: m_out  = m_out | wd;
                4'd3: m_out  = m_out & ~wd;
                4'd4: m_cfg  = wd;
                default: ;
            endcase
        end
        m_stat = nstat;
    endtask

    task automatic wr_reg(input string req, input logic [3:0] a, input logic [7:0] d);
        cyc(req, 1'b1, 1'b1, 1'b0, a, d, 2'b00, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic rd_reg(input string req, input logic [3:0] a);
        cyc(req, 1'b1, 1'b0, 1'b1, a, 8'h00, 2'b00, 2'b00, 1'b0, 1'b0);
    endtask

    task automatic ev(input string req, input logic [1:0] rx, input logic [1:0] tx, input logic ts, input logic tc);
        cyc(req, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00, rx, tx, ts, tc);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        rst_n = 1'b0;
        bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        rx_rdy_set = 0; tx_rdy_set = 0; tmr_set = 0; tmr_clr = 0;
        m_stat = 0; m_mask = 0; m_vec = 0; m_out = 0; m_cfg = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg("R1", 4'd0);
        rd_reg("R1", 4'd1);
        rd_reg("R1", 4'd4);
        // R3 mask write leaves status alone
        wr_reg("R3", 4'd0, 8'hFF);
        rd_reg("R3", 4'd0);
        cyc("R3", 1'b0, 1'b0, 1'b1, 4'd0, 8'h00, 2'b00, 2'b00, 1'b0, 1'b0);
        // R8 receiver ready set and read-clear
        ev("R8", 2'b01, 2'b00, 1'b0, 1'b0);
        rd_reg("R8", 4'd0);
        rd_reg("R8", 4'd6);
        rd_reg("R8", 4'd0);
        // R12 set and clear collide on channel B receiver bit
        ev("R12", 2'b10, 2'b00, 1'b0, 1'b0);
        cyc("R12", 1'b1, 1'b0, 1'b1, 4'd8, 8'h00, 2'b10, 2'b00, 1'b0, 1'b0);
        rd_reg("R12", 4'd0);
        rd_reg("R12", 4'd8);
        // R10 command codes
        wr_reg("R10", 4'd5, 8'h04);
        rd_reg("R10", 4'd0);
        wr_reg("R10", 4'd5, 8'h0C);
        rd_reg("R10", 4'd0);
        wr_reg("R10", 4'd5, 8'h08);
        rd_reg("R10", 4'd0);
        wr_reg("R10", 4'd7, 8'hF3);
        rd_reg("R10", 4'd0);
        // R9 transmitter set and data-write clear
        ev("R9", 2'b00, 2'b10, 1'b0, 1'b0);
        rd_reg("R9", 4'd0);
        wr_reg("R9", 4'd8, 8'h41);
        rd_reg("R9", 4'd0);
        // R11 timer bit, including a collision (R12)
        ev("R11", 2'b00, 2'b00, 1'b1, 1'b0);
        rd_reg("R11", 4'd0);
        ev("R11 R12", 2'b00, 2'b00, 1'b1, 1'b1);
        rd_reg("R11", 4'd0);
        ev("R11", 2'b00, 2'b00, 1'b0, 1'b1);
        rd_reg("R11", 4'd0);
        // R2 masked sources do not raise the request
        ev("R2", 2'b11, 2'b11, 1'b1, 1'b0);
        wr_reg("R2", 4'd0, 8'hC4);
        rd_reg("R13", 4'd0);
        wr_reg("R2", 4'd0, 8'h08);
        rd_reg("R2", 4'd0);
        // R4 vector, R5 R6 output port, R7 configuration
        wr_reg("R4", 4'd1, 8'hA5);
        rd_reg("R4", 4'd1);
        wr_reg("R5", 4'd2, 8'hF0);
        wr_reg("R5", 4'd2, 8'h0F);
        rd_reg("R5", 4'd2);
        wr_reg("R6", 4'd3, 8'h3C);
        rd_reg("R6", 4'd3);
        wr_reg("R7", 4'd4, 8'h5A);
        rd_reg("R7", 4'd4);
        // R13 reserved bits stay zero under a random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] op;
            op = 3'($urandom % 5);
            cyc("R13", ($urandom % 5) != 0, op == 3'd1 || op == 3'd2, op == 3'd3,
                4'($urandom % 10), 8'($urandom),
                2'($urandom % 8 == 0 ? $urandom : 0), 2'($urandom % 8 == 0 ? $urandom : 0),
                ($urandom % 10) == 0, ($urandom % 10) == 0);
        end
        rd_reg("R13", 4'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule